// File: doc/BRIEF.md
# Capture Controller with Packed Byte Dump

This block runs a fixed-depth sample capture memory. Software drives it with single-cycle writes to an 8-bit control word: one bit returns the controller to idle, one bit arms it to wait for a trigger, and one bit starts a capture at once without a trigger. Once armed, a trigger pulse starts filling. Each sample is a 10-bit analog value plus an 8-bit logic value. Filling runs until the memory holds a full set of samples. The controller then reports a data-ready code on its status byte.

A dump request made in the data-ready state streams the whole memory out as bytes over a valid/ready handshake. Each sample becomes three bytes. Every byte carries six payload bits, and the analog and logic fields are split across the byte boundaries. After the last byte the controller goes back to data-ready, so the same capture can be dumped again.

Top module: `cap_ctrl`

## Requirements
- R1: After reset, `status` reads 0x00 (idle) and `dump_valid` is low.
- R2: A control write with bit 0 set gives idle. A write with bit 1 set, made in idle, gives armed (status 0x01). A write of 0x00 changes nothing. The status codes are idle 0x00, armed 0x01, filling 0x02, data-ready 0x03 and dumping 0x04.
- R3: A `trig_in` pulse in armed state moves to filling. A trigger in idle is ignored. Samples presented while armed are not stored.
- R4: A control write with bit 3 set (value 8) moves from idle or armed straight to filling without a trigger. A following write of 0x00 leaves the fill running.
- R5: In filling, each cycle with `smp_valid` high stores one sample at the next address, starting from 0. After exactly 1024 stored samples the status becomes data-ready. Samples offered after that do not change the memory.
- R6: A dump started from data-ready delivers exactly 3072 bytes, sample 0 first, three bytes per sample in order. While bytes stream, the status reads dumping.
- R7: Byte 0 bits [5:0] carry analog [5:0]. Byte 1 bits [3:0] carry analog [9:6], and byte 1 bits [5:4] carry logic [1:0]. Byte 2 bits [5:0] carry logic [7:2].
- R8: Bits [7:6] of every dumped byte are zero.
- R9: While `dump_valid` is high and `byte_ready` is low, `dump_valid` stays high and `dump_byte` is held.
- R10: A `dump_req` made in any state other than data-ready produces no bytes and does not change the state.
- R11: A control write with bit 0 set returns to idle from any state. It ends a dump in progress on the next cycle, with `dump_valid` low.
- R12: After the last byte of a dump, the status returns to data-ready and no further bytes appear. A repeated dump returns the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_data | input | 8 | Control word: bit 0 reset-to-idle, bit 1 arm, bit 3 force |
| trig_in | input | 1 | Trigger pulse |
| smp_valid | input | 1 | Sample present this cycle |
| smp_analog | input | 10 | Analog sample value |
| smp_logic | input | 8 | Logic sample value |
| dump_req | input | 1 | Request to stream the capture out |
| byte_ready | input | 1 | Consumer accepts the current byte |
| status | output | 8 | State code |
| dump_valid | output | 1 | `dump_byte` holds a valid byte |
| dump_byte | output | 8 | Packed dump byte |

## Verification
Each capture stores analog and logic values computed from the sample index and a per-capture seed. Because the two fields change independently, a swapped or shifted bit in the packing shows up as a mismatch in one specific byte lane. Consumer readiness follows three patterns: always ready, ready on two cycles out of three, and a sparse pattern. Comparing these separates a correct byte hold under back-pressure from one that slips or repeats bytes.

Captures are started by a trigger after arming, by force from idle, and by force from armed. Some captures have gaps in the sample stream and one receives extra samples after it is full. A fill and a dump are each cut short with reset-to-idle, and dump requests are issued in states other than data-ready. Together these cases show whether the fill count and the state changes are correct.

// File: rtl/capdump_pkg.sv
package capdump_pkg;

  localparam int ANA_W       = 10;
  localparam int LOG_W       = 8;
  localparam int WORD_W      = ANA_W + LOG_W;
  localparam int BYTES_PER   = 3;

  localparam int CTL_RESET_BIT = 0;
  localparam int CTL_ARM_BIT   = 1;
  localparam int CTL_FORCE_BIT = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_FILL  = 3'd2,
    ST_READY = 3'd3,
    ST_DUMP  = 3'd4
  } cap_state_e;

  function automatic logic [7:0] status_code(cap_state_e s);
    return {5'b0, s};
  endfunction

  // Memory word is {logic[7:0], analog[9:0]}.
  function automatic logic [7:0] pack_byte(logic [WORD_W-1:0] w, logic [1:0] lane);
    logic [7:0] b;
    case (lane)
      2'd0:    b = {2'b00, w[5:0]};
      2'd1:    b = {2'b00, w[ANA_W+1:ANA_W], w[9:6]};
      default: b = {2'b00, w[WORD_W-1:ANA_W+2]};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import capdump_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_data,
  input  logic          trig_in,
  input  logic          smp_valid,
  input  logic          dump_req,
  input  logic          dump_done,
  output cap_state_e    state,
  output logic [7:0]    status,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          dump_start,
  output logic          abort
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic do_rst, do_arm, do_force;
  logic unused_ctl_bits;
  cap_state_e state_n;

  assign do_rst   = ctrl_wr & ctrl_data[CTL_RESET_BIT];
  assign do_arm   = ctrl_wr & ctrl_data[CTL_ARM_BIT];
  assign do_force = ctrl_wr & ctrl_data[CTL_FORCE_BIT];
  assign unused_ctl_bits = ^{ctrl_data[7:4], ctrl_data[2]};

  always_comb begin
    state_n = state;
    if (do_rst) begin
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (do_force)    state_n = ST_FILL;
          else if (do_arm) state_n = ST_ARMED;
        end
        ST_ARMED: if (do_force || trig_in) state_n = ST_FILL;
        ST_FILL:  if (smp_valid && wr_addr == LAST_ADDR) state_n = ST_READY;
        ST_READY: if (dump_req) state_n = ST_DUMP;
        ST_DUMP:  if (dump_done) state_n = ST_READY;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  assign wr_en      = (state == ST_FILL) && smp_valid;
  assign dump_start = (state == ST_READY) && dump_req && !do_rst;
  assign abort      = do_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      status  <= status_code(ST_IDLE);
      wr_addr <= '0;
    end else begin
      state  <= state_n;
      status <= status_code(state_n);
      if (state != ST_FILL)  wr_addr <= '0;
      else if (smp_valid)    wr_addr <= wr_addr + 1'b1;
    end
  end

  // R5: the last stored sample leads to data-ready
  a_r5_full_to_ready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && smp_valid && wr_addr == LAST_ADDR && !do_rst)
      |=> (status == status_code(ST_READY)));

  // R11: reset-to-idle wins from any state
  a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
    do_rst |=> (state == ST_IDLE && status == 8'h00));

  // R3: trigger in idle has no effect
  a_r3_idle_trig_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && trig_in && !ctrl_wr) |=> (state == ST_IDLE));

  // R12: end of dump returns to data-ready
  a_r12_done_ready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DUMP && dump_done && !do_rst) |=> (status == status_code(ST_READY)));

endmodule

// File: rtl/dump_packer.sv
module dump_packer
  import capdump_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              byte_ready,
  input  logic [WORD_W-1:0] rdata,
  output logic [AW-1:0]     raddr,
  output logic              dump_valid,
  output logic [7:0]        dump_byte,
  output logic              done
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [1:0]    LAST_LANE = 2'(BYTES_PER - 1);

  typedef enum logic [1:0] {P_IDLE, P_FETCH, P_LOAD, P_SEND} pk_state_e;

  pk_state_e         pst;
  logic [1:0]        lane;
  logic [WORD_W-1:0] word_r;

  assign done = (pst == P_SEND) && byte_ready && (lane == LAST_LANE) && (raddr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      pst        <= P_IDLE;
      raddr      <= '0;
      lane       <= '0;
      dump_valid <= 1'b0;
      dump_byte  <= '0;
      word_r     <= '0;
    end else begin
      case (pst)
        P_IDLE: begin
          if (start) begin
            raddr <= '0;
            pst   <= P_FETCH;
          end
        end
        P_FETCH: pst <= P_LOAD;
        P_LOAD: begin
          word_r     <= rdata;
          dump_byte  <= pack_byte(rdata, 2'd0);
          lane       <= 2'd0;
          dump_valid <= 1'b1;
          pst        <= P_SEND;
        end
        P_SEND: begin
          if (byte_ready) begin
            if (lane == LAST_LANE) begin
              dump_valid <= 1'b0;
              if (raddr == LAST_ADDR) begin
                pst <= P_IDLE;
              end else begin
                raddr <= raddr + 1'b1;
                pst   <= P_FETCH;
              end
            end else begin
              lane      <= lane + 2'd1;
              dump_byte <= pack_byte(word_r, lane + 2'd1);
            end
          end
        end
        default: pst <= P_IDLE;
      endcase
    end
  end

  // R9: a byte not taken is held
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (dump_valid && !byte_ready && !abort) |=> (dump_valid && $stable(dump_byte)));

  // R8: the two top bits never carry data
  a_r8_top_zero: assert property (@(posedge clk) disable iff (rst)
    dump_valid |-> (dump_byte[7:6] == 2'b00));

  // R12: nothing follows the final byte
  a_r12_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !dump_valid);

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import capdump_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_data,
  input  logic             trig_in,
  input  logic             smp_valid,
  input  logic [ANA_W-1:0] smp_analog,
  input  logic [LOG_W-1:0] smp_logic,
  input  logic             dump_req,
  input  logic             byte_ready,
  output logic [7:0]       status,
  output logic             dump_valid,
  output logic [7:0]       dump_byte
);

  cap_state_e        state;
  logic              wr_en, dump_start, abort, dump_done;
  logic [AW-1:0]     wr_addr, raddr;
  logic [WORD_W-1:0] rdata;

  cap_fsm #(.DEPTH(DEPTH)) i_fsm (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .trig_in(trig_in), .smp_valid(smp_valid), .dump_req(dump_req),
    .dump_done(dump_done), .state(state), .status(status), .wr_en(wr_en),
    .wr_addr(wr_addr), .dump_start(dump_start), .abort(abort)
  );

  cap_mem #(.DEPTH(DEPTH), .W(WORD_W)) i_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata({smp_logic, smp_analog}),
    .raddr(raddr), .rdata(rdata)
  );

  dump_packer #(.DEPTH(DEPTH)) i_packer (
    .clk(clk), .rst(rst), .start(dump_start), .abort(abort),
    .byte_ready(byte_ready), .rdata(rdata), .raddr(raddr),
    .dump_valid(dump_valid), .dump_byte(dump_byte), .done(dump_done)
  );

  // R6: bytes only stream in the dumping state
  a_r6_stream_in_dump: assert property (@(posedge clk) disable iff (rst)
    dump_valid |-> (status == status_code(ST_DUMP)));

  // R10: entering the dumping state needs a request seen in data-ready
  a_r10_dump_needs_req: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DUMP && $past(state) != ST_DUMP)
      |-> ($past(dump_req) && $past(state) == ST_READY));

endmodule

// File: tb/test_cap_ctrl.sv
module test_cap_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 1024;
  localparam int NB   = 3 * NS;
  localparam logic [7:0] S_IDLE = 8'h00, S_ARMED = 8'h01, S_FILL = 8'h02,
                         S_READY = 8'h03, S_DUMP = 8'h04;

  logic clk = 1'b0, rst = 1'b1;
  logic ctrl_wr = 0, trig_in = 0, smp_valid = 0, dump_req = 0, byte_ready = 0;
  logic [7:0] ctrl_data = 0;
  logic [9:0] smp_analog = 0;
  logic [7:0] smp_logic = 0;
  logic [7:0] status, dump_byte;
  logic dump_valid;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_ctrl i_cap_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .trig_in(trig_in), .smp_valid(smp_valid), .smp_analog(smp_analog),
    .smp_logic(smp_logic), .dump_req(dump_req), .byte_ready(byte_ready),
    .status(status), .dump_valid(dump_valid), .dump_byte(dump_byte)
  );

  function automatic logic [9:0] ana(int seed, int j);
    return 10'((j * 37 + seed * 101 + (j >> 5)) & 10'h3FF);
  endfunction

  function automatic logic [7:0] lgc(int seed, int j);
    return 8'(((j * 13) ^ (seed * 29) ^ (j >> 2)) & 8'hFF);
  endfunction

  function automatic logic [7:0] exp_byte(int seed, int k);
    int j = k / 3;
    logic [9:0] a = ana(seed, j);
    logic [7:0] l = lgc(seed, j);
    case (k % 3)
      0:       return {2'b00, a[5:0]};
      1:       return {2'b00, l[1:0], a[9:6]};
      default: return {2'b00, l[7:2]};
    endcase
  endfunction

  function automatic bit rdy_pat(int mode, int cyc);
    case (mode)
      0:       return 1'b1;
      1:       return (cyc % 3) != 1;
      default: return ((cyc * 7) % 5) < 2;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_wr = 1; ctrl_data = v;
    @(negedge clk);
    ctrl_wr = 0; ctrl_data = 0;
  endtask

  task automatic pulse_trig();
    trig_in = 1;
    @(negedge clk);
    trig_in = 0;
  endtask

  task automatic fill(int seed, bit gaps, int n);
    int not_fill = 0, stray = 0;
    for (int j = 0; j < n; j++) begin
      if (gaps && (j % 7) == 3) begin
        smp_valid = 0;
        @(negedge clk);
      end
      smp_valid = 1;
      smp_analog = ana(seed, j);
      smp_logic = lgc(seed, j);
      dump_req = (j == 500);
      if (status != S_FILL) not_fill++;
      if (dump_valid) stray++;
      @(negedge clk);
    end
    smp_valid = 0; dump_req = 0;
    chk(not_fill == 0, "R5", "cycles not filling during fill", not_fill, 0);
    if (n > 500) chk(stray == 0, "R10", "bytes from request during fill", stray, 0);
    if (n == NS) chk(status == S_READY, "R5", "status after full fill", status, S_READY);
  endtask

  task automatic dump(int seed, int mode, int max_b, bit full);
    int cnt = 0, mism = 0, top = 0, hold_bad = 0, st_bad = 0, cyc = 0;
    int first_act = 0, first_exp = 0;
    logic prev_stall = 0;
    logic [7:0] prev_byte = 0;
    dump_req = 1;
    @(negedge clk);
    dump_req = 0;
    while (cnt < max_b && cyc < 40000) begin
      byte_ready = rdy_pat(mode, cyc);
      if (prev_stall && !(dump_valid && dump_byte == prev_byte)) hold_bad++;
      if (dump_valid) begin
        if (status != S_DUMP) st_bad++;
        if (dump_byte[7:6] != 2'b00) top++;
        if (dump_byte != exp_byte(seed, cnt)) begin
          if (mism == 0) begin first_act = dump_byte; first_exp = exp_byte(seed, cnt); end
          mism++;
        end
        if (byte_ready) cnt++;
      end
      prev_stall = dump_valid && !byte_ready;
      prev_byte = dump_byte;
      cyc++;
      @(negedge clk);
    end
    byte_ready = 0;
    chk(mism == 0, "R7", "packed byte content", first_act, first_exp);
    chk(top == 0, "R8", "bytes with top bits set", top, 0);
    chk(st_bad == 0, "R6", "status not dumping while streaming", st_bad, 0);
    if (mode != 0) chk(hold_bad == 0, "R9", "byte not held under stall", hold_bad, 0);
    if (full) begin
      int extra = 0;
      chk(cnt == NB, "R6", "byte count", cnt, NB);
      chk(status == S_READY, "R12", "status after dump", status, S_READY);
      byte_ready = 1;
      for (int i = 0; i < 12; i++) begin
        if (dump_valid) extra++;
        @(negedge clk);
      end
      byte_ready = 0;
      chk(extra == 0, "R12", "bytes after final byte", extra, 0);
    end
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(status == S_IDLE, "R1", "status after reset", status, S_IDLE);
    chk(!dump_valid, "R1", "dump_valid after reset", dump_valid, 0);

    // R10: request in idle
    dump_req = 1; @(negedge clk); dump_req = 0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin if (dump_valid) seen++; @(negedge clk); end
    chk(seen == 0 && status == S_IDLE, "R10", "dump in idle", seen, 0);

    // R3: trigger in idle
    pulse_trig();
    chk(status == S_IDLE, "R3", "trigger in idle", status, S_IDLE);

    // R2: arm sequence
    wr_ctrl(8'h01);
    chk(status == S_IDLE, "R2", "after reset bit", status, S_IDLE);
    wr_ctrl(8'h02);
    chk(status == S_ARMED, "R2", "after arm bit", status, S_ARMED);
    wr_ctrl(8'h00);
    chk(status == S_ARMED, "R2", "after clear write", status, S_ARMED);

    // R3: samples while armed are dropped, trigger starts fill
    for (int j = 0; j < 4; j++) begin
      smp_valid = 1; smp_analog = ana(7, j); smp_logic = lgc(7, j);
      @(negedge clk);
    end
    smp_valid = 0;
    chk(status == S_ARMED, "R3", "samples while armed", status, S_ARMED);
    pulse_trig();
    chk(status == S_FILL, "R3", "trigger while armed", status, S_FILL);

    fill(1, 1'b1, NS);
    // R5: extra samples after full must not overwrite
    for (int j = 0; j < 6; j++) begin
      smp_valid = 1; smp_analog = ana(9, j); smp_logic = lgc(9, j);
      @(negedge clk);
    end
    smp_valid = 0;
    chk(status == S_READY, "R5", "status after extra samples", status, S_READY);

    dump(1, 1, NB, 1'b1);
    dump(1, 0, NB, 1'b1);   // R12 repeat dump

    // R11: abort a dump
    dump(1, 2, 100, 1'b0);
    wr_ctrl(8'h01);
    chk(status == S_IDLE, "R11", "status after abort", status, S_IDLE);
    chk(!dump_valid, "R11", "dump_valid after abort", dump_valid, 0);
    dump_req = 1; @(negedge clk); dump_req = 0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin if (dump_valid) seen++; @(negedge clk); end
    chk(seen == 0, "R10", "dump after abort", seen, 0);

    // R4: force from idle
    wr_ctrl(8'h08);
    chk(status == S_FILL, "R4", "force from idle", status, S_FILL);
    wr_ctrl(8'h00);
    chk(status == S_FILL, "R4", "clear after force", status, S_FILL);
    fill(2, 1'b0, NS);
    dump(2, 2, NB, 1'b1);

    // R4: force from armed, then R11 mid-fill reset
    wr_ctrl(8'h01);
    wr_ctrl(8'h02);
    wr_ctrl(8'h08);
    chk(status == S_FILL, "R4", "force from armed", status, S_FILL);
    fill(5, 1'b0, 300);
    wr_ctrl(8'h01);
    chk(status == S_IDLE, "R11", "reset during fill", status, S_IDLE);

    wr_ctrl(8'h02);
    pulse_trig();
    fill(3, 1'b1, NS);
    dump(3, 0, NB, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule